// File: doc/BRIEF.md
# Analog Column Clock Distribution Network

The block builds one clock per analog column from a small set of shared timing sources. First, two auxiliary lines are each picked from the clock outputs of eight digital blocks. Then each column chooses one of four candidates: system clock A, system clock B, auxiliary line 0 or auxiliary line 1. The chosen candidate is divided by four before it reaches the column.

Every clock in the block is modelled as a single-cycle enable pulse in the system clock domain. Each column divider counts the cycles in which its selected source is high and emits a one-cycle pulse after every fourth such cycle. Two control words hold the selections. They are loaded through a plain write port and can be read back.

Top module: `colclk_net`

## Requirements
- R1: A synchronous reset clears both control words to zero and clears every divider, and col_out is all zero in the cycle after reset.
- R2: aux_out[0] equals dig_clk indexed by aux word bits [2:0], and aux_out[1] equals dig_clk indexed by aux word bits [5:3], combinationally.
- R3: Column n takes its source from column word bits [2n+1:2n], encoded as 0 = src_a, 1 = src_b, 2 = aux_out[0], 3 = aux_out[1].
- R4: col_out[n] is high for one cycle, in the cycle after every fourth cycle in which the selected source of column n was high. Between such pulses col_out[n] is low.
- R5: A column-word write that changes the field of column n clears that column's divider, and the source value in the write cycle is not counted. The first pulse then comes one cycle after the fourth new-source pulse. A write that leaves the field of column n unchanged does not disturb that column.
- R6: Writing with wr_addr = 0 loads the aux word from wr_data[5:0], and writing with wr_addr = 1 loads the column word from wr_data[7:0]. Reading with rd_addr = 0 returns the aux word with bits [7:6] as zero, and reading with rd_addr = 1 returns the column word.
- R7: The four columns select and divide independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_a | input | 1 | System clock A enable pulse |
| src_b | input | 1 | System clock B enable pulse |
| dig_clk | input | 8 | Digital block clock enable pulses |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | 1 | Write target: 0 aux word, 1 column word |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 aux word, 1 column word |
| rd_data | output | 8 | Read data, unused bits zero |
| aux_out | output | 2 | Auxiliary line enables |
| col_out | output | 4 | Divided column clock enables |

## Verification
The bench goes after the fourth pulse of each divider. A divider off by one would pulse after the third or the fifth pulse, and one that counts idle cycles would pulse while its source is silent. It writes a column word mid-count that changes one field and keeps the others. A design that resets every column, or none, then pulses too early or too late on the wrong columns. It also writes all ones to the aux word to catch stray upper bits in the readback, and drives one source at a time to expose a swapped select encoding.

// File: rtl/colclk_net.sv
module colclk_net #(
  parameter int NDIG = 8,
  parameter int NCOL = 4,
  parameter int DIV  = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_a,
  input  logic            src_b,
  input  logic [NDIG-1:0] dig_clk,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [1:0]      aux_out,
  output logic [NCOL-1:0] col_out
);
  localparam int SW = $clog2(NDIG);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [2*SW-1:0]   aux_sel_q;
  logic [2*NCOL-1:0] col_sel_q;
  logic [NCOL-1:0]   col_src;
  logic              unused_bits;

  wire wr_aux = wr_en && !wr_addr;
  wire wr_col = wr_en && wr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_sel_q <= '0;
      col_sel_q <= '0;
    end else begin
      if (wr_aux) aux_sel_q <= wr_data[2*SW-1:0];
      if (wr_col) col_sel_q <= wr_data[2*NCOL-1:0];
    end
  end

  assign aux_out[0]  = dig_clk[aux_sel_q[SW-1:0]];
  assign aux_out[1]  = dig_clk[aux_sel_q[2*SW-1:SW]];
  assign rd_data     = rd_addr ? DW'(col_sel_q) : DW'(aux_sel_q);
  assign unused_bits = ^wr_data;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [1:0]    fs;
    logic          src;
    logic          pulse_q;
    logic [CW-1:0] cnt;
    logic          restart;

    assign fs = col_sel_q[2*c +: 2];
    assign restart = wr_col && (wr_data[2*c +: 2] != fs);

    always_comb begin
      case (fs)
        2'd0:    src = src_a;
        2'd1:    src = src_b;
        2'd2:    src = aux_out[0];
        default: src = aux_out[1];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst || restart) begin
        cnt     <= '0;
        pulse_q <= 1'b0;
      end else begin
        pulse_q <= src && (cnt == LAST);
        if (src) cnt <= (cnt == LAST) ? '0 : CW'(cnt + 1'b1);
      end
    end

    assign col_src[c] = src;
    assign col_out[c] = pulse_q;
  end
endmodule

module colclk_net_chk #(
  parameter int NDIG = 8,
  parameter int NCOL = 4,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NDIG-1:0] dig_clk,
  input logic            wr_en,
  input logic            wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            rd_addr,
  input logic [DW-1:0]   rd_data,
  input logic [1:0]      aux_out,
  input logic [NCOL-1:0] col_out,
  input logic [NCOL-1:0] col_src,
  input logic [2*NCOL-1:0] col_sel_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (col_out == '0));

  // R6
  aux_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_addr |-> (rd_data[DW-1:6] == '0));

  // R2
  aux_line_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_addr |-> (aux_out[0] == dig_clk[rd_data[2:0]] &&
                  aux_out[1] == dig_clk[rd_data[5:3]]));

  for (genvar c = 0; c < NCOL; c++) begin : g_chk
    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      col_out[c] |=> !col_out[c]);

    // R4
    pulse_has_src_chk: assert property (@(posedge clk) disable iff (rst)
      (col_out[c] && !$past(rst)) |-> $past(col_src[c]));

    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr && wr_data[2*c +: 2] != col_sel_q[2*c +: 2]) |=> !col_out[c]);
  end
endmodule

bind colclk_net colclk_net_chk #(.NDIG(NDIG), .NCOL(NCOL), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .dig_clk(dig_clk), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .aux_out(aux_out),
  .col_out(col_out), .col_src(col_src), .col_sel_q(col_sel_q)
);

// File: tb/colclk_net_bench.sv
`timescale 1ns/1ps
module colclk_net_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_a = 1'b0, src_b = 1'b0;
  logic [7:0] dig_clk = '0;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] aux_out;
  logic [3:0] col_out;

  int checks = 0;
  int fails  = 0;
  int m_aux [2];
  int m_col [4];
  int m_cnt [4];

  colclk_net u_colclk_net (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .dig_clk(dig_clk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .aux_out(aux_out), .col_out(col_out)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic aux_of(int k);
    return dig_clk[m_aux[k]];
  endfunction

  function automatic logic src_of(int c);
    case (m_col[c])
      0: return src_a;
      1: return src_b;
      2: return aux_of(0);
      default: return aux_of(1);
    endcase
  endfunction

  // inputs are set before the call, at or after a negedge
  task automatic step(string tag);
    logic [3:0] exp;
    #1;
    check("R2", {30'd0, aux_out}, {30'd0, aux_of(1), aux_of(0)});
    for (int c = 0; c < 4; c++) begin
      logic s;
      logic rs;
      s  = src_of(c);
      rs = wr_en && wr_addr && (int'(wr_data[2*c +: 2]) != m_col[c]);
      if (rst || rs) begin
        exp[c] = 1'b0;
        m_cnt[c] = 0;
      end else begin
        exp[c] = s && (m_cnt[c] == 3);
        if (s) m_cnt[c] = (m_cnt[c] == 3) ? 0 : m_cnt[c] + 1;
      end
    end
    if (rst) begin
      m_aux[0] = 0; m_aux[1] = 0;
      for (int c = 0; c < 4; c++) m_col[c] = 0;
    end else if (wr_en && !wr_addr) begin
      m_aux[0] = int'(wr_data[2:0]);
      m_aux[1] = int'(wr_data[5:3]);
    end else if (wr_en && wr_addr) begin
      for (int c = 0; c < 4; c++) m_col[c] = int'(wr_data[2*c +: 2]);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, col_out, exp);
  endtask

  task automatic idle_inputs();
    src_a = 0; src_b = 0; dig_clk = '0; wr_en = 0;
  endtask

  task automatic write_word(logic a, logic [7:0] d, string tag);
    idle_inputs();
    wr_en = 1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 0;
  endtask

  task automatic pulse_a(int n, string tag);
    for (int i = 0; i < n; i++) begin
      idle_inputs(); src_a = 1; step(tag);
      idle_inputs(); step(tag);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_aux[0] = 0; m_aux[1] = 0;
    for (int c = 0; c < 4; c++) begin m_col[c] = 0; m_cnt[c] = 0; end
    @(negedge clk);
    rst = 1; step("R1"); step("R1");
    rst = 0;
    rd_addr = 0; #1; check("R1", rd_data, 0);
    rd_addr = 1; #1; check("R1", rd_data, 0);
    check("R1", col_out, 0);

    // R6 readback with unused bits
    write_word(0, 8'hFF, "R6");
    rd_addr = 0; #1; check("R6", rd_data, 8'h3F);
    write_word(1, 8'hE4, "R6");
    rd_addr = 1; #1; check("R6", rd_data, 8'hE4);

    // R2 aux select: aux0 = 5, aux1 = 2
    write_word(0, 8'h15, "R2");
    rd_addr = 0; #1; check("R2", rd_data, 8'h15);
    for (int i = 0; i < 8; i++) begin
      idle_inputs(); dig_clk = 8'(1 << i); step("R2");
    end

    // R3 encoding: col0=A, col1=B, col2=aux0, col3=aux1 (word E4)
    pulse_a(4, "R3");
    for (int i = 0; i < 4; i++) begin idle_inputs(); src_b = 1; step("R3"); end
    for (int i = 0; i < 4; i++) begin idle_inputs(); dig_clk = 8'h20; step("R3"); end
    for (int i = 0; i < 4; i++) begin idle_inputs(); dig_clk = 8'h04; step("R3"); end

    // R5 restart: all on A, count 2, change only col1, then same-value write
    write_word(1, 8'h00, "R5");
    pulse_a(2, "R5");
    write_word(1, 8'h00, "R5");
    idle_inputs(); wr_en = 1; wr_addr = 1; wr_data = 8'h00; src_a = 1; step("R5");
    idle_inputs(); wr_en = 1; wr_addr = 1; wr_data = 8'h04; src_a = 1; step("R5");
    idle_inputs(); step("R5");
    pulse_a(6, "R5");

    // R4 / R7 random traffic
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      src_a   = ($urandom % 2) == 0;
      src_b   = ($urandom % 3) == 0;
      dig_clk = 8'($urandom);
      if (($urandom % 20) == 0) begin
        wr_en = 1; wr_addr = 1'($urandom); wr_data = 8'($urandom);
      end
      step(($urandom % 2) == 0 ? "R4" : "R7");
    end
    idle_inputs();
    rd_addr = 1; #1;
    begin
      int w;
      w = 0;
      for (int c = 0; c < 4; c++) w = w | (m_col[c] << (2 * c));
      check("R6", rd_data, w);
    end
    rst = 1; step("R1");
    rst = 0; step("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule